// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block picks which of four oscillators drives the CPU clock domain, from reset release through run time. After reset it always starts on the ordinary internal high-speed oscillator. It holds the CPU-enable flag low for a fixed reset-processing interval, counted in reference ticks, before the CPU may run. Software turns the other three sources on with plain enable inputs: a fast internal oscillator, an external main oscillator and an external subsystem oscillator. It then asks for a source through a request strobe and a two-bit source field.

Each source has its own stabilization timer. The timer counts reference ticks while the oscillator runs, and a status bit reports when the timer has expired. The main and subsystem waits come from software inputs. The fast internal source uses a fixed wait of 100 µs. With the default 1 µs tick that is 100 ticks, so using the fast source takes two steps: enable it, then request it once it is stable. A request for a source that is not stable is refused and sets a sticky error bit. A granted request hands over through one cycle in which no source is selected. The reference tick is assumed to be 1 µs, and the default hold of 3000 ticks therefore lies inside the required 2.12 ms to 5.84 ms window.

Top module: `clk_src_seq`

## Requirements
- R1: While reset is low and just after it is released, `src_sel` is 4'b0001, `osc_on` is 4'b0001, `cpu_en` is 0 and `sw_err` is 0. Bit i of `src_sel`, `osc_on` and `src_stable` stands for source code i, where 0 = internal high-speed, 1 = fast internal, 2 = external main and 3 = external subsystem.
- R2: `cpu_en` is 0 until RST_HOLD_TICKS ticks have been counted after reset release. It is 1 from the cycle the count reaches that value, and it stays 1 until the next reset.
- R3: The internal high-speed oscillator (bit 0 of `osc_on`) is always on. Bits 1 to 3 of `osc_on` follow `fast_en`, `main_en` and `sub_en` one cycle later, except while that source is selected or being handed over to.
- R4: `src_stable[i]` is 1 only when `osc_on[i]` is 1 and at least the wait for that source has been counted in ticks with the source on. The waits are 0 for source 0, FAST_WAIT_TICKS for source 1, `main_wait` for source 2 and `sub_wait` for source 3. The count clears while the source is off, and it does not advance on cycles without `tick`.
- R5: A `req_stb` with `cpu_en` 1, for a source other than the current one whose `src_stable` bit is 1, makes `src_sel` 0 in the cycle after the strobe edge and the one-hot code of the new source one cycle later. A request for the current source changes nothing.
- R6: A request for a different source whose `src_stable` bit is 0 is ignored: `src_sel` keeps its value and `sw_err` becomes 1 and stays 1 until reset.
- R7: Clearing the enable of the selected source leaves its `osc_on` bit at 1. The bit drops two cycles after the CPU has moved to another source.
- R8: A switch from the fast internal source back to the internal high-speed source (code 0) is always granted.
- R9: `src_sel` never has more than one bit set.
- R10: Requests made while `cpu_en` is 0 have no effect on `src_sel` or `sw_err`.
- R11: Asserting reset at any time returns the select, the enables in effect, the timers, `cpu_en` and `sw_err` to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the hold interval |
| tick | input | 1 | Reference time tick, one cycle wide (1 µs nominal) |
| fast_en | input | 1 | Software enable of the fast internal oscillator |
| main_en | input | 1 | Software enable of the external main oscillator |
| sub_en | input | 1 | Software enable of the external subsystem oscillator |
| main_wait | input | TW | Stabilization wait of the main oscillator, in ticks |
| sub_wait | input | TW | Stabilization wait of the subsystem oscillator, in ticks |
| req_stb | input | 1 | One-cycle switch request |
| req_src | input | 2 | Requested source code (0 to 3) |
| src_sel | output | 4 | One-hot CPU clock source select |
| osc_on | output | 4 | Oscillators currently running |
| src_stable | output | 4 | Stabilization timer expired, per source |
| cpu_en | output | 1 | CPU may run; low during the hold interval |
| sw_err | output | 1 | Sticky flag for a refused switch request |

## Verification
The switch logic is tried with directed sequences first. A fast-source request made before its timer expires tells a proper refusal apart from a premature grant. A request made exactly when the timer expires separates the exact wait count from an off-by-one. A switch away from a source whose enable was cleared shows whether the oscillator is kept alive while selected and released afterwards. Random rounds then draw enable sets, software waits and requested codes. They mix granted, refused and same-source requests, which separates the stability gate from the self-request rule and from the one-cycle idle gap. Requests during the hold interval and with the tick stopped show whether cpu_en and the tick truly gate the block.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  localparam int NSRC = 4;
  localparam int SW   = $clog2(NSRC);

  typedef enum logic [SW-1:0] {
    SRC_IHS  = 2'd0,
    SRC_FAST = 2'd1,
    SRC_MAIN = 2'd2,
    SRC_SUB  = 2'd3
  } src_e;

  function automatic logic [NSRC-1:0] src_onehot(input src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clk_seq_hold.sv
module clk_seq_hold #(
  parameter int HOLD_TICKS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic run_ok
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] cnt_q;

  assign run_ok = (cnt_q == HW'(HOLD_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (tick && !run_ok)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_seq_stab.sv
module clk_seq_stab #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          running,
  input  logic [TW-1:0] limit,
  output logic          settled
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!running)
      cnt_q <= '0;
    else if (tick && (cnt_q != '1))
      cnt_q <= cnt_q + 1'b1;
  end

  assign settled = running && (cnt_q >= limit);
endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
  import clk_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_ok,
  input  logic            req_stb,
  input  logic [SW-1:0]   req_src,
  input  logic [NSRC-1:0] sw_en,
  input  logic [NSRC-1:0] settled,
  output logic [NSRC-1:0] sel_oh,
  output logic [NSRC-1:0] osc_run,
  output logic            refused
);
  src_e cur_q, tgt_q;
  logic gap_q;
  src_e want;

  assign want   = src_e'(req_src);
  assign sel_oh = gap_q ? '0 : src_onehot(cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= SRC_IHS;
      tgt_q   <= SRC_IHS;
      gap_q   <= 1'b0;
      refused <= 1'b0;
    end else if (gap_q) begin
      cur_q <= tgt_q;
      gap_q <= 1'b0;
    end else if (req_stb && run_ok && (want != cur_q)) begin
      if (settled[want]) begin
        tgt_q <= want;
        gap_q <= 1'b1;
      end else begin
        refused <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_run <= NSRC'(1);
    end else begin
      for (int i = 0; i < NSRC; i++)
        osc_run[i] <= sw_en[i] || (cur_q == src_e'(i)) || (gap_q && (tgt_q == src_e'(i)));
    end
  end
endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq
  import clk_seq_pkg::*;
#(
  parameter int RST_HOLD_TICKS  = 3000,
  parameter int FAST_WAIT_TICKS = 100,
  parameter int TW              = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            fast_en,
  input  logic            main_en,
  input  logic            sub_en,
  input  logic [TW-1:0]   main_wait,
  input  logic [TW-1:0]   sub_wait,
  input  logic            req_stb,
  input  logic [1:0]      req_src,
  output logic [3:0]      src_sel,
  output logic [3:0]      osc_on,
  output logic [3:0]      src_stable,
  output logic            cpu_en,
  output logic            sw_err
);
  logic [NSRC-1:0] sw_en;
  logic [TW-1:0]   limit_v [NSRC];

  assign sw_en      = {sub_en, main_en, fast_en, 1'b1};
  assign limit_v[0] = '0;
  assign limit_v[1] = TW'(FAST_WAIT_TICKS);
  assign limit_v[2] = main_wait;
  assign limit_v[3] = sub_wait;

  clk_seq_hold #(.HOLD_TICKS(RST_HOLD_TICKS)) hold_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_ok(cpu_en)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_stab
    clk_seq_stab #(.TW(TW)) stab_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .running(osc_on[g]), .limit(limit_v[g]), .settled(src_stable[g])
    );
  end

  clk_seq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .run_ok(cpu_en),
    .req_stb(req_stb), .req_src(req_src), .sw_en(sw_en),
    .settled(src_stable), .sel_oh(src_sel), .osc_run(osc_on),
    .refused(sw_err)
  );
endmodule

// File: rtl/clk_src_seq_chk.sv
module clk_src_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src_sel,
  input logic [3:0] osc_on,
  input logic [3:0] src_stable,
  input logic       cpu_en,
  input logic       sw_err
);
  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel)); // R9

  AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 4'b0000) |=> (src_sel == $past(src_sel) || src_sel == 4'b0000)); // R5

  AST_NEW_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 4'b0000 && $past(src_sel) == 4'b0000) |-> ((src_sel & src_stable) != 4'b0000)); // R4

  AST_CPU_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |=> cpu_en); // R2

  AST_IDLE_DURING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |-> (src_sel == 4'b0001 && !sw_err)); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err |=> sw_err); // R6

  AST_SEL_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel & ~osc_on) == 4'b0000); // R7
endmodule

bind clk_src_seq clk_src_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .osc_on(osc_on),
  .src_stable(src_stable), .cpu_en(cpu_en), .sw_err(sw_err)
);

// File: tb/clk_src_seq_tb_top.sv
module clk_src_seq_tb_top;
  localparam int HOLD = 3000;
  localparam int FWAIT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic fast_en = 1'b0, main_en = 1'b0, sub_en = 1'b0;
  logic [15:0] main_wait = 16'd20, sub_wait = 16'd30;
  logic req_stb = 1'b0;
  logic [1:0] req_src = 2'd0;
  logic [3:0] src_sel, osc_on, src_stable;
  logic cpu_en, sw_err;

  int checks = 0;
  int errors = 0;
  int mcur = 0;
  bit merr = 1'b0;

  always #10 clk = ~clk;

  clk_src_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast_en(fast_en), .main_en(main_en),
    .sub_en(sub_en), .main_wait(main_wait), .sub_wait(sub_wait), .req_stb(req_stb),
    .req_src(req_src), .src_sel(src_sel), .osc_on(osc_on), .src_stable(src_stable),
    .cpu_en(cpu_en), .sw_err(sw_err)
  );

  function automatic logic [3:0] oh(input int s);
    return 4'b0001 << s;
  endfunction

  function automatic bit grant(input int req, input logic [3:0] en);
    return (req == 0) || en[req];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a request; mcur/merr model the expected outcome.
  task automatic switch_to(input int s, input bit ok, input string tag);
    req_src = 2'(s);
    req_stb = 1'b1;
    @(negedge clk);
    req_stb = 1'b0;
    if (s == mcur) begin
      check({tag, " same source"}, src_sel, oh(mcur));
    end else if (ok) begin
      check({tag, " idle gap"}, src_sel, 4'b0000);
      mcur = s;
    end else begin
      check({tag, " refused keeps select"}, src_sel, oh(mcur));
      merr = 1'b1;
    end
    @(negedge clk);
    check({tag, " select"}, src_sel, oh(mcur));
    check({tag, " error flag"}, sw_err, merr);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fast_en = 1'b0; main_en = 1'b0; sub_en = 1'b0; req_stb = 1'b0; tick = 1'b1;
    mcur = 0; merr = 1'b0;
    @(negedge clk);
    check("R1 select in reset", src_sel, 4'b0001);
    check("R1 osc_on in reset", osc_on, 4'b0001);
    check("R1 cpu_en in reset", cpu_en, 1'b0);
    check("R11 error in reset", sw_err, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd8317));
    wait_n(2);
    do_reset();
    // R2 hold interval and R10 requests during hold
    wait_n(HOLD - 10);
    req_src = 2'd1; req_stb = 1'b1;
    @(negedge clk);
    req_stb = 1'b0;
    check("R10 request in hold ignored", src_sel, 4'b0001);
    check("R10 no error in hold", sw_err, 1'b0);
    wait_n(HOLD - 1 - (HOLD - 9));
    check("R2 cpu_en low before count", cpu_en, 1'b0);
    @(negedge clk);
    check("R2 cpu_en high at count", cpu_en, 1'b1);
    check("R3 main off without enable", osc_on[2], 1'b0);

    // R4 fast wait exact, R3 enable follows
    fast_en = 1'b1;
    @(negedge clk);
    check("R3 fast oscillator on", osc_on[1], 1'b1);
    wait_n(FWAIT - 1);
    check("R4 fast not stable before wait", src_stable[1], 1'b0);
    @(negedge clk);
    check("R4 fast stable after wait", src_stable[1], 1'b1);
    switch_to(1, 1'b1, "R5 to fast");
    switch_to(0, 1'b1, "R8 fast back to ihs");
    switch_to(0, 1'b1, "R5 self request");

    // R7 clearing enable of selected source
    main_en = 1'b1;
    wait_n(30);
    switch_to(2, 1'b1, "R5 to main");
    main_en = 1'b0;
    wait_n(5);
    check("R7 selected main kept on", osc_on[2], 1'b1);
    switch_to(0, 1'b1, "R7 leave main");
    wait_n(2);
    check("R7 main off after leaving", osc_on[2], 1'b0);
    switch_to(2, 1'b0, "R6 unstable main refused");

    // R4 tick gating
    tick = 1'b0;
    sub_en = 1'b1;
    wait_n(100);
    check("R4 sub not stable without ticks", src_stable[3], 1'b0);
    tick = 1'b1;
    wait_n(40);
    check("R4 sub stable with ticks", src_stable[3], 1'b1);
    switch_to(3, 1'b1, "R5 to sub");

    // R11 reset mid-run
    do_reset();
    check("R11 timers cleared", src_stable, 4'b0001);
    wait_n(HOLD + 2);
    check("R2 cpu_en after second reset", cpu_en, 1'b1);

    // Random rounds
    for (int it = 0; it < 40; it++) begin
      logic [3:0] en;
      int r;
      en = 4'($urandom);
      fast_en = en[1]; main_en = en[2]; sub_en = en[3];
      main_wait = 16'(1 + $urandom % 60);
      sub_wait = 16'(1 + $urandom % 60);
      wait_n(130);
      r = int'($urandom % 4);
      if (r != mcur) begin
        if (grant(r, en)) switch_to(r, 1'b1, "R5 random grant");
        else switch_to(r, 1'b0, "R6 random refusal");
      end else begin
        switch_to(r, 1'b1, "R5 random self");
      end
      check("R9 select at most one bit", 32'($countones(src_sel) <= 1), 32'd1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule